// File: doc/BRIEF.md
# Power Mode State Controller

This block decides which power mode the device is in, one clock at a time. It watches a per-CPU wait vector, where a 1 means that CPU sits in a wait-for-interrupt or wait-for-event state, and a per-CPU deep-sleep request vector. It also watches a wake-event line, a debug power-up request and a one-way "low-power startup done" input. From these it produces a 2-bit mode code, enables for the CPU, high-frequency, peripheral and low-speed clock domains, and a read-only 32-bit status word.

A deep-sleep request can arrive before the low-power circuits are ready. In that case the block settles in SLEEP rather than DEEPSLEEP. Once readiness is recorded, it moves into DEEPSLEEP by itself, provided the request still stands. While a debug session is active, the block also holds the device at SLEEP, which keeps the high-frequency clock running for the debug connection.

Top module: `pmc_power_ctrl`

## Requirements
- R1: While `rst_n` is low, `mode_o` is 0 (RESET), `status_o` is 0 and every clock enable is 0.
- R2: On the first rising clock edge after `rst_n` goes high, the mode becomes 1 (ACTIVE).
- R3: If any bit of `cpu_wait_i` is 0, or `wake_i` is 1, the mode is ACTIVE after the next edge. This holds from SLEEP and from DEEPSLEEP alike. In ACTIVE all four clock enables are 1.
- R4: If every CPU waits and at least one CPU has no deep request, the mode becomes 2 (SLEEP). In SLEEP `cpu_clk_en_o` is 0, while `hf_clk_en_o`, `periph_clk_en_o` and `lf_clk_en_o` are 1.
- R5: The mode becomes 3 (DEEPSLEEP) only if every CPU waits with its `cpu_deep_i` bit set, the ready flag is 1 and the debug flag is 0. In DEEPSLEEP only `lf_clk_en_o` is 1.
- R6: If deep sleep is requested while the ready flag is 0, the mode is SLEEP. The edge after the ready flag becomes 1, the mode turns to DEEPSLEEP if the request is still present.
- R7: While the debug flag is 1, a full deep-sleep request yields SLEEP. The edge after the flag clears, the mode turns to DEEPSLEEP.
- R8: `status_o[1:0]` is the mode, bit 4 is the debug flag, bit 5 is the ready flag, and every other bit is 0.
- R9: The debug flag equals `dbg_req_i` as sampled at the previous edge.
- R10: The ready flag becomes 1 at the edge where `lp_done_i` is sampled high. It then stays 1 until reset, whatever `lp_done_i` does afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset indication |
| cpu_wait_i | input | N_CPU | Per-CPU wait state, 1 = waiting |
| cpu_deep_i | input | N_CPU | Per-CPU deep-sleep request |
| wake_i | input | 1 | Wake event |
| lp_done_i | input | 1 | Low-power circuit startup complete |
| dbg_req_i | input | 1 | Debug power-up request |
| mode_o | output | 2 | Current mode: 0 RESET, 1 ACTIVE, 2 SLEEP, 3 DEEPSLEEP |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| hf_clk_en_o | output | 1 | High-frequency clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| lf_clk_en_o | output | 1 | Low-speed clock enable |
| status_o | output | 32 | Read-only status word |

## Verification
The hardest state to reach is the promotion from a demoted SLEEP into DEEPSLEEP. It needs a full deep-sleep request held steady with the ready flag still 0, and the ready flag can only be set once per reset. The bench therefore runs the demotion scenario first, before anything pulses `lp_done_i`. It holds the request for several edges to show the mode stays at SLEEP, then raises `lp_done_i` and checks the status word and the mode on each of the next two edges. The debug hold is reached in a similar way. The debug request is raised while a CPU still runs, and only then do all CPUs ask for deep sleep.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        PM_RESET  = 2'd0,
        PM_ACTIVE = 2'd1,
        PM_SLEEP  = 2'd2,
        PM_DEEP   = 2'd3
    } pm_mode_e;

    localparam int STAT_W   = 32;
    localparam int MODE_LSB = 0;
    localparam int DBG_BIT  = 4;
    localparam int RDY_BIT  = 5;

    typedef struct packed {
        logic ready;
        logic dbg;
    } flags_t;

    typedef struct packed {
        pm_mode_e mode;
    } fsm_st_t;

    typedef struct packed {
        logic cpu;
        logic hf;
        logic periph;
        logic lf;
    } clk_en_t;

endpackage

// File: rtl/pmc_request_decode.sv
module pmc_request_decode #(
    parameter int N_CPU = 2
) (
    input  logic [N_CPU-1:0] cpu_wait_i,
    input  logic [N_CPU-1:0] cpu_deep_i,
    input  logic             wake_i,
    output logic             any_run_o,
    output logic             all_deep_o
);
    logic [N_CPU-1:0] deep_ok;
    logic [N_CPU-1:0] running;

    for (genvar g = 0; g < N_CPU; g++) begin : g_cpu
        assign running[g] = ~cpu_wait_i[g];
        assign deep_ok[g] = cpu_wait_i[g] & cpu_deep_i[g];
    end

    always_comb begin
        any_run_o  = (|running) | wake_i;
        all_deep_o = &deep_ok;
    end

endmodule

// File: rtl/pmc_ready_tracker.sv
module pmc_ready_tracker
    import pmc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lp_done_i,
    input  logic dbg_req_i,
    output logic ready_o,
    output logic dbg_o
);
    flags_t fl_d, fl_q;

    always_comb begin
        fl_d       = fl_q;
        fl_d.ready = fl_q.ready | lp_done_i;
        fl_d.dbg   = dbg_req_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign ready_o = fl_q.ready;
    assign dbg_o   = fl_q.dbg;

    // R10
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> ready_o);
    // R10
    ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lp_done_i |=> ready_o);
    // R9
    dbg_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req_i |=> dbg_o);

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
    import pmc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     any_run_i,
    input  logic     all_deep_i,
    input  logic     ready_i,
    input  logic     dbg_i,
    output pm_mode_e mode_o
);
    fsm_st_t st_d, st_q;
    logic    deep_allowed;

    always_comb begin
        deep_allowed = all_deep_i & ready_i & ~dbg_i;
        st_d         = st_q;
        unique case (st_q.mode)
            PM_RESET: st_d.mode = PM_ACTIVE;
            default: begin
                if (any_run_i)         st_d.mode = PM_ACTIVE;
                else if (deep_allowed) st_d.mode = PM_DEEP;
                else                   st_d.mode = PM_SLEEP;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.mode <= PM_RESET;
        else        st_q      <= st_d;
    end

    assign mode_o = st_q.mode;

    // R2
    leave_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == PM_RESET) |=> (mode_o == PM_ACTIVE));
    // R3
    wake_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_run_i |=> (mode_o == PM_ACTIVE));
    // R6
    not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |=> (mode_o != PM_DEEP));
    // R7
    dbg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_i |=> (mode_o != PM_DEEP));
    // R4
    sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != PM_RESET && !any_run_i && !all_deep_i) |=> (mode_o == PM_SLEEP));

endmodule

// File: rtl/pmc_status_pack.sv
module pmc_status_pack
    import pmc_pkg::*;
(
    input  pm_mode_e          mode_i,
    input  logic              dbg_i,
    input  logic              ready_i,
    output logic [STAT_W-1:0] status_o,
    output clk_en_t           en_o
);
    always_comb begin
        status_o                     = '0;
        status_o[MODE_LSB+1:MODE_LSB] = mode_i;
        status_o[DBG_BIT]            = dbg_i;
        status_o[RDY_BIT]            = ready_i;
    end

    always_comb begin
        en_o = '0;
        unique case (mode_i)
            PM_ACTIVE: en_o = '{cpu: 1'b1, hf: 1'b1, periph: 1'b1, lf: 1'b1};
            PM_SLEEP:  en_o = '{cpu: 1'b0, hf: 1'b1, periph: 1'b1, lf: 1'b1};
            PM_DEEP:   en_o = '{cpu: 1'b0, hf: 1'b0, periph: 1'b0, lf: 1'b1};
            default:   en_o = '0;
        endcase
    end

endmodule

// File: rtl/pmc_power_ctrl.sv
module pmc_power_ctrl
    import pmc_pkg::*;
#(
    parameter int N_CPU = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CPU-1:0]  cpu_wait_i,
    input  logic [N_CPU-1:0]  cpu_deep_i,
    input  logic              wake_i,
    input  logic              lp_done_i,
    input  logic              dbg_req_i,
    output logic [1:0]        mode_o,
    output logic              cpu_clk_en_o,
    output logic              hf_clk_en_o,
    output logic              periph_clk_en_o,
    output logic              lf_clk_en_o,
    output logic [STAT_W-1:0] status_o
);
    logic     any_run, all_deep, ready, dbg;
    pm_mode_e mode;
    clk_en_t  en;

    pmc_request_decode #(.N_CPU(N_CPU)) u_dec (
        .cpu_wait_i (cpu_wait_i),
        .cpu_deep_i (cpu_deep_i),
        .wake_i     (wake_i),
        .any_run_o  (any_run),
        .all_deep_o (all_deep)
    );

    pmc_ready_tracker u_rdy (
        .clk       (clk),
        .rst_n     (rst_n),
        .lp_done_i (lp_done_i),
        .dbg_req_i (dbg_req_i),
        .ready_o   (ready),
        .dbg_o     (dbg)
    );

    pmc_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_run_i  (any_run),
        .all_deep_i (all_deep),
        .ready_i    (ready),
        .dbg_i      (dbg),
        .mode_o     (mode)
    );

    pmc_status_pack u_pack (
        .mode_i   (mode),
        .dbg_i    (dbg),
        .ready_i  (ready),
        .status_o (status_o),
        .en_o     (en)
    );

    assign mode_o          = mode;
    assign cpu_clk_en_o    = en.cpu;
    assign hf_clk_en_o     = en.hf;
    assign periph_clk_en_o = en.periph;
    assign lf_clk_en_o     = en.lf;

    // R5
    deep_clocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd3) |-> (!hf_clk_en_o && !periph_clk_en_o && lf_clk_en_o));
    // R5
    deep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 2'd3) ##1 (mode_o == 2'd3) |-> $past(all_deep && ready && !dbg));
    // R8
    status_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[STAT_W-1:RDY_BIT+1] == '0) && (status_o[DBG_BIT-1:2] == '0));

endmodule

// File: tb/pmc_power_ctrl_test.sv
module pmc_power_ctrl_test;
    localparam int N = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  cpu_wait = '0, cpu_deep = '0;
    logic          wake = 1'b0, lp_done = 1'b0, dbg_req = 1'b0;
    logic [1:0]    mode;
    logic          cpu_en, hf_en, per_en, lf_en;
    logic [31:0]   status;
    int            errors = 0, checks = 0;
    bit            finished = 0;

    always #5 clk = ~clk;

    pmc_power_ctrl #(.N_CPU(N)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_wait_i(cpu_wait), .cpu_deep_i(cpu_deep),
        .wake_i(wake), .lp_done_i(lp_done), .dbg_req_i(dbg_req),
        .mode_o(mode), .cpu_clk_en_o(cpu_en), .hf_clk_en_o(hf_en),
        .periph_clk_en_o(per_en), .lf_clk_en_o(lf_en), .status_o(status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // advance n rising edges, then sample 1 ns after the last one
    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic [N-1:0] w, input logic [N-1:0] d);
        @(negedge clk);
        cpu_wait = w;
        cpu_deep = d;
    endtask

    function automatic logic [3:0] ens();
        return {cpu_en, hf_en, per_en, lf_en};
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        step(2);
        chk("R1 mode", {30'd0, mode}, 32'd0);
        chk("R1 status", status, 32'd0);
        chk("R1 enables", {28'd0, ens()}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R2 before edge", {30'd0, mode}, 32'd0);
        step(1);
        chk("R2 active", {30'd0, mode}, 32'd1);
        chk("R3 active enables", {28'd0, ens()}, 32'hF);
    endtask

    task automatic t_sleep();
        drive(2'b10, 2'b00);
        step(1);
        chk("R3 one cpu runs", {30'd0, mode}, 32'd1);
        drive(2'b11, 2'b00);
        step(1);
        chk("R4 sleep", {30'd0, mode}, 32'd2);
        chk("R4 sleep enables", {28'd0, ens()}, 32'h7);
        drive(2'b11, 2'b01);
        step(1);
        chk("R4 partial deep", {30'd0, mode}, 32'd2);
    endtask

    task automatic t_demote();
        drive(2'b11, 2'b11);
        step(3);
        chk("R6 demoted", {30'd0, mode}, 32'd2);
        chk("R8 status not ready", status, 32'h2);
        @(negedge clk);
        lp_done = 1'b1;
        step(1);
        chk("R10 ready set", status, 32'h22);
        @(negedge clk);
        lp_done = 1'b0;
        step(1);
        chk("R6 promoted", {30'd0, mode}, 32'd3);
        chk("R5 deep enables", {28'd0, ens()}, 32'h1);
        chk("R8 status deep", status, 32'h23);
        step(3);
        chk("R10 ready sticky", status[5], 32'd1);
    endtask

    task automatic t_wake();
        @(negedge clk);
        wake = 1'b1;
        step(1);
        chk("R3 wake from deep", {30'd0, mode}, 32'd1);
        @(negedge clk);
        wake = 1'b0;
        step(1);
        chk("R5 back to deep", {30'd0, mode}, 32'd3);
        drive(2'b01, 2'b01);
        step(1);
        chk("R3 cpu leaves wait", {30'd0, mode}, 32'd1);
    endtask

    task automatic t_debug();
        @(negedge clk);
        dbg_req = 1'b1;
        step(1);
        chk("R9 dbg mirror", status[4], 32'd1);
        drive(2'b11, 2'b11);
        step(3);
        chk("R7 held in sleep", {30'd0, mode}, 32'd2);
        chk("R8 status dbg", status, 32'h32);
        @(negedge clk);
        dbg_req = 1'b0;
        step(1);
        chk("R9 dbg cleared", status[4], 32'd0);
        chk("R7 still sleep", {30'd0, mode}, 32'd2);
        step(1);
        chk("R7 deep after dbg", {30'd0, mode}, 32'd3);
    endtask

    task automatic t_rereset();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 reset clears ready", status, 32'd0);
        chk("R1 reset mode", {30'd0, mode}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        cpu_wait = 2'b11;
        cpu_deep = 2'b11;
        step(3);
        chk("R10 ready cleared stays", status[5], 32'd0);
        chk("R6 demoted again", {30'd0, mode}, 32'd2);
    endtask

    initial begin
        t_reset();
        t_sleep();
        t_demote();
        t_wake();
        t_debug();
        t_rereset();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule